// File: doc/BRIEF.md
# Identifier-Tagged Translation Cache

This block is a small fully associative cache of address translations. Every entry holds a virtual page number and a physical frame number, together with the identifier of the virtual processor that created it. Identifier 0 belongs to the host. Each virtual CPU is given its own nonzero identifier. Translations owned by several guests and by the host can therefore sit side by side. A switch between guest and host changes only the identifier that the requester presents, and entries that are already cached stay valid.

A lookup request carries an identifier and a virtual page. It is accepted on a valid/ready handshake and produces a registered result one cycle later. The result is either a hit with its frame, or a walk request that tells an external page-table walker to fetch the translation. The walker returns it through the plain fill port.

Two plain invalidate ports are provided:
- one clears a single page belonging to a given identifier;
- one clears every entry that carries a given identifier.

Back-pressure follows these rules. A result stays on the output, unchanged, until `rs_ready` is high at a clock edge. `lk_ready` is high whenever no result is pending or the pending result is being consumed in that cycle. While `lk_ready` is low, a requester must hold its lookup.

Top module: `vtag_tlb`

## Requirements
- R1: After reset no entry is valid and `rs_valid` is low, so every lookup reports a walk.
- R2: A lookup hits only when an entry's stored identifier and its virtual page both equal the request. The matching frame appears on `rs_pfn`, with `rs_hit` high, in the cycle after the lookup is accepted.
- R3: A lookup that finds no match gives `rs_walk`=1 and `rs_hit`=0. `rs_hit` and `rs_walk` are never both high, and neither is high without `rs_valid`.
- R4: The same virtual page cached under identifier 0 and under a nonzero identifier resolves to each owner's own frame. Changing the identifier presented on lookups flushes nothing.
- R5: A fill whose identifier and page match an existing entry overwrites that entry's frame. It uses no second entry, so no two valid entries ever match one request.
- R6: A fill with no match goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 and advances by one after each such replacement.
- R7: A single-page invalidate clears only the entry whose identifier and page both equal `ipg_id`/`ipg_vpn`. The same page under another identifier stays valid.
- R8: An invalidate-by-identifier clears, in one cycle, every entry carrying `iid_id`. Entries of other identifiers stay valid.
- R9: A lookup accepted in the same cycle as a fill or an invalidate sees the contents from before that edge, and the next lookup sees the change. A fill in the same cycle as an invalidate is written after the invalidation and remains valid.
- R10: While `rs_valid` is high and `rs_ready` is low, the result holds its values and `lk_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_id | input | 4 | Identifier of the requester |
| lk_vpn | input | 20 | Virtual page to translate |
| rs_valid | output | 1 | Result present |
| rs_ready | input | 1 | Consumer takes the result |
| rs_hit | output | 1 | Translation found |
| rs_walk | output | 1 | No translation; page-table walk needed |
| rs_pfn | output | 20 | Physical frame of a hit |
| fill_en | input | 1 | Write a translation |
| fill_id | input | 4 | Identifier of the new entry |
| fill_vpn | input | 20 | Virtual page of the new entry |
| fill_pfn | input | 20 | Physical frame of the new entry |
| ipg_en | input | 1 | Single-page invalidate |
| ipg_id | input | 4 | Identifier of the page to clear |
| ipg_vpn | input | 20 | Virtual page to clear |
| iid_en | input | 1 | Invalidate by identifier |
| iid_id | input | 4 | Identifier whose entries are cleared |

## Verification
The bench builds the block with its default values: 8 entries, a 4-bit identifier, and 20-bit page and frame numbers. With eight entries the array fills in a few cycles. The bench can therefore reach the point where every entry is valid and watch the round-robin pointer pick victims. It can also check that a freed slot is preferred over the pointer, and that overwriting a matching entry consumes no slot. Identifier 0 and several nonzero identifiers share pages, which exposes identifier-qualified matching and clearing. Same-cycle collisions and a stalled result consumer are driven explicitly.

// File: rtl/vtag_tlb_pkg.sv
package vtag_tlb_pkg;
  // Where a fill is placed
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,  // existing entry with same identifier and page
    SLOT_FREE  = 2'd1,  // lowest invalid entry
    SLOT_ROUND = 2'd2   // round-robin victim
  } slot_src_e;
endpackage

// File: rtl/vtag_tlb_slot_pick.sv
module vtag_tlb_slot_pick
  import vtag_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] fill_match,
  output logic [IDX_W-1:0]   slot_idx,
  output slot_src_e          slot_src
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] reuse_idx, free_idx;
  logic             any_free;

  always_comb begin
    reuse_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fill_match[i]) reuse_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
  end

  always_comb begin
    if (|fill_match) begin
      slot_idx = reuse_idx;
      slot_src = SLOT_REUSE;
    end else if (any_free) begin
      slot_idx = free_idx;
      slot_src = SLOT_FREE;
    end else begin
      slot_idx = rr_q;
      slot_src = SLOT_ROUND;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (fill_en && slot_src == SLOT_ROUND)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // A free slot is chosen only when it really is invalid
  AST_FREE_SLOT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && slot_src == SLOT_FREE) |-> !ent_valid[slot_idx]); // R6
  // Round-robin only when the array is full
  AST_ROUND_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && slot_src == SLOT_ROUND) |-> (&ent_valid)); // R6
endmodule

// File: rtl/vtag_tlb_array.sv
module vtag_tlb_array #(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    lk_id,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [PFN_W-1:0]   lk_pfn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [ID_W-1:0]    fill_id,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  output logic [ENTRIES-1:0] fill_match,
  input  logic               ipg_en,
  input  logic [ID_W-1:0]    ipg_id,
  input  logic [VPN_W-1:0]   ipg_vpn,
  input  logic               iid_en,
  input  logic [ID_W-1:0]    iid_id,
  output logic [ENTRIES-1:0] ent_valid
);
  logic [ID_W-1:0]    id_q  [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] kill;

  // Per-entry comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = valid_q[g] && id_q[g] == lk_id   && vpn_q[g] == lk_vpn;
    assign fill_match[g] = valid_q[g] && id_q[g] == fill_id && vpn_q[g] == fill_vpn;
    assign kill[g] = valid_q[g] &&
                     ((ipg_en && id_q[g] == ipg_id && vpn_q[g] == ipg_vpn) ||
                      (iid_en && id_q[g] == iid_id));
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_pfn = lk_pfn | pfn_q[i];
  end

  // Invalidation first, then the fill on top of it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        id_q[i]  <= '0;
        vpn_q[i] <= '0;
        pfn_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (kill[i]) valid_q[i] <= 1'b0;
        if (fill_en && fill_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          id_q[i]    <= fill_id;
          vpn_q[i]   <= fill_vpn;
          pfn_q[i]   <= fill_pfn;
        end
      end
    end
  end

  assign ent_valid = valid_q;

  // Checker state: the last invalidate, when no fill accompanied it
  logic             chk_iid_v, chk_ipg_v;
  logic [ID_W-1:0]  chk_iid_id, chk_ipg_id;
  logic [VPN_W-1:0] chk_ipg_vpn;
  logic [ENTRIES-1:0] stale_iid, stale_ipg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_iid_v <= 1'b0; chk_ipg_v <= 1'b0;
      chk_iid_id <= '0;  chk_ipg_id <= '0; chk_ipg_vpn <= '0;
    end else begin
      chk_iid_v   <= iid_en && !fill_en;
      chk_ipg_v   <= ipg_en && !fill_en;
      chk_iid_id  <= iid_id;
      chk_ipg_id  <= ipg_id;
      chk_ipg_vpn <= ipg_vpn;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      stale_iid[i] = valid_q[i] && id_q[i] == chk_iid_id;
      stale_ipg[i] = valid_q[i] && id_q[i] == chk_ipg_id && vpn_q[i] == chk_ipg_vpn;
    end
  end

  AST_IID_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    chk_iid_v |-> stale_iid == '0); // R8
  AST_IPG_CLEARS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ipg_v |-> stale_ipg == '0); // R7
  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R5
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)]); // R9
endmodule

// File: rtl/vtag_tlb.sv
module vtag_tlb
  import vtag_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [ID_W-1:0]  lk_id,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic             rs_hit,
  output logic             rs_walk,
  output logic [PFN_W-1:0] rs_pfn,
  input  logic             fill_en,
  input  logic [ID_W-1:0]  fill_id,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             ipg_en,
  input  logic [ID_W-1:0]  ipg_id,
  input  logic [VPN_W-1:0] ipg_vpn,
  input  logic             iid_en,
  input  logic [ID_W-1:0]  iid_id
);
  logic [ENTRIES-1:0] lk_match, fill_match, ent_valid;
  logic [PFN_W-1:0]   lk_pfn;
  logic [IDX_W-1:0]   slot_idx;
  slot_src_e          slot_src;

  vtag_tlb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en),
    .ent_valid(ent_valid), .fill_match(fill_match),
    .slot_idx(slot_idx), .slot_src(slot_src)
  );

  vtag_tlb_array #(.ENTRIES(ENTRIES), .ID_W(ID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .lk_id(lk_id), .lk_vpn(lk_vpn), .lk_match(lk_match), .lk_pfn(lk_pfn),
    .fill_en(fill_en), .fill_idx(slot_idx), .fill_id(fill_id),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_match(fill_match),
    .ipg_en(ipg_en), .ipg_id(ipg_id), .ipg_vpn(ipg_vpn),
    .iid_en(iid_en), .iid_id(iid_id), .ent_valid(ent_valid)
  );

  // Registered lookup result with output back-pressure
  logic             rs_valid_q, rs_hit_q;
  logic [PFN_W-1:0] rs_pfn_q;
  logic             accept;

  assign lk_ready = !rs_valid_q || rs_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_hit_q   <= 1'b0;
      rs_pfn_q   <= '0;
    end else if (accept) begin
      rs_valid_q <= 1'b1;
      rs_hit_q   <= |lk_match;
      rs_pfn_q   <= (|lk_match) ? lk_pfn : '0;
    end else if (rs_ready) begin
      rs_valid_q <= 1'b0;
    end
  end

  assign rs_valid = rs_valid_q;
  assign rs_hit   = rs_valid_q && rs_hit_q;
  assign rs_walk  = rs_valid_q && !rs_hit_q;
  assign rs_pfn   = rs_pfn_q;

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_pfn) && $stable(rs_hit))); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |-> !lk_ready); // R10
  AST_HIT_WALK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_hit && rs_walk) && ((rs_hit || rs_walk) == rs_valid)); // R3
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid); // R2
endmodule

// File: tb/vtag_tlb_test.sv
`timescale 1ns/1ps
module vtag_tlb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, rs_ready = 1;
  logic [3:0]  lk_id = 0, fill_id = 0, ipg_id = 0, iid_id = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, fill_pfn = 0, ipg_vpn = 0;
  logic fill_en = 0, ipg_en = 0, iid_en = 0;
  logic lk_ready, rs_valid, rs_hit, rs_walk;
  logic [19:0] rs_pfn;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vtag_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_id(lk_id), .lk_vpn(lk_vpn), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_hit(rs_hit), .rs_walk(rs_walk), .rs_pfn(rs_pfn),
    .fill_en(fill_en), .fill_id(fill_id), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .ipg_en(ipg_en), .ipg_id(ipg_id), .ipg_vpn(ipg_vpn),
    .iid_en(iid_en), .iid_id(iid_id)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; lk_valid = 0; fill_en = 0; ipg_en = 0; iid_en = 0; rs_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(input logic [3:0] id, input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    fill_en = 1; fill_id = id; fill_vpn = vpn; fill_pfn = pfn;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic lookup(input logic [3:0] id, input logic [19:0] vpn, input bit exp_hit,
                        input logic [19:0] exp_pfn, input string req);
    @(negedge clk);
    lk_valid = 1; lk_id = id; lk_vpn = vpn; rs_ready = 1;
    @(posedge clk); #1;
    check(rs_valid && rs_hit == exp_hit && rs_walk == !exp_hit, req, {30'd0, rs_hit, rs_walk}, {30'd0, exp_hit, !exp_hit});
    if (exp_hit) check(rs_pfn == exp_pfn, req, {12'd0, rs_pfn}, {12'd0, exp_pfn});
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check(rs_valid == 0, "R1", {31'd0, rs_valid}, 0);
    lookup(4'd0, 20'h0, 0, 0, "R1");
    lookup(4'd1, 20'h12345, 0, 0, "R1");
  endtask

  task automatic t_match();
    do_reset();
    fill(4'd1, 20'h00ABC, 20'h11111);
    lookup(4'd1, 20'h00ABC, 1, 20'h11111, "R2");
    lookup(4'd2, 20'h00ABC, 0, 0, "R3 id mismatch");
    lookup(4'd1, 20'h00ABD, 0, 0, "R3 page mismatch");
  endtask

  task automatic t_coexist();
    do_reset();
    fill(4'd0, 20'h00400, 20'hA0000);
    fill(4'd5, 20'h00400, 20'hB0000);
    fill(4'd9, 20'h00400, 20'hC0000);
    lookup(4'd5, 20'h00400, 1, 20'hB0000, "R4 guest");
    lookup(4'd0, 20'h00400, 1, 20'hA0000, "R4 host");
    lookup(4'd9, 20'h00400, 1, 20'hC0000, "R4 guest2");
    lookup(4'd5, 20'h00400, 1, 20'hB0000, "R4 back to guest");
  endtask

  task automatic t_overwrite();
    do_reset();
    fill(4'd2, 20'h00050, 20'h00001);
    fill(4'd2, 20'h00050, 20'h00002);
    lookup(4'd2, 20'h00050, 1, 20'h00002, "R5 overwrite");
    for (int k = 1; k < 8; k++) fill(4'd2, 20'h00050 + k, 20'h00100 + k);
    lookup(4'd2, 20'h00050, 1, 20'h00002, "R5 no duplicate slot");
    for (int k = 1; k < 8; k++) lookup(4'd2, 20'h00050 + k, 1, 20'h00100 + k, "R5 all resident");
  endtask

  task automatic t_replace();
    do_reset();
    for (int k = 0; k < 8; k++) fill(4'd1, 20'h00100 + k, 20'h00200 + k);
    fill(4'd1, 20'h001FF, 20'h002FF);
    lookup(4'd1, 20'h00100, 0, 0, "R6 rr victim entry 0");
    lookup(4'd1, 20'h00101, 1, 20'h00201, "R6 entry 1 kept");
    lookup(4'd1, 20'h001FF, 1, 20'h002FF, "R6 new present");
    fill(4'd1, 20'h001FE, 20'h002FE);
    lookup(4'd1, 20'h00101, 0, 0, "R6 rr victim entry 1");
    // free a slot: it is preferred over the pointer (now at 2)
    @(negedge clk); ipg_en = 1; ipg_id = 4'd1; ipg_vpn = 20'h00105;
    @(negedge clk); ipg_en = 0;
    fill(4'd1, 20'h001FD, 20'h002FD);
    lookup(4'd1, 20'h00102, 1, 20'h00202, "R6 free slot first");
    lookup(4'd1, 20'h001FD, 1, 20'h002FD, "R6 filled free slot");
  endtask

  task automatic t_inv_page();
    do_reset();
    fill(4'd3, 20'h00777, 20'h03333);
    fill(4'd4, 20'h00777, 20'h04444);
    fill(4'd3, 20'h00778, 20'h03338);
    @(negedge clk); ipg_en = 1; ipg_id = 4'd3; ipg_vpn = 20'h00777;
    @(negedge clk); ipg_en = 0;
    lookup(4'd3, 20'h00777, 0, 0, "R7 cleared");
    lookup(4'd4, 20'h00777, 1, 20'h04444, "R7 other id kept");
    lookup(4'd3, 20'h00778, 1, 20'h03338, "R7 other page kept");
  endtask

  task automatic t_inv_id();
    do_reset();
    for (int k = 0; k < 3; k++) fill(4'd6, 20'h00600 + k, 20'h06000 + k);
    fill(4'd0, 20'h00600, 20'h00600);
    fill(4'd7, 20'h00601, 20'h07001);
    @(negedge clk); iid_en = 1; iid_id = 4'd6;
    @(negedge clk); iid_en = 0;
    for (int k = 0; k < 3; k++) lookup(4'd6, 20'h00600 + k, 0, 0, "R8 cleared");
    lookup(4'd0, 20'h00600, 1, 20'h00600, "R8 host kept");
    lookup(4'd7, 20'h00601, 1, 20'h07001, "R8 other guest kept");
  endtask

  task automatic t_same_cycle();
    do_reset();
    @(negedge clk);
    fill_en = 1; fill_id = 4'd3; fill_vpn = 20'h00077; fill_pfn = 20'h0ABCD;
    lk_valid = 1; lk_id = 4'd3; lk_vpn = 20'h00077;
    @(posedge clk); #1;
    check(rs_walk == 1, "R9 old state seen", {31'd0, rs_walk}, 1);
    @(negedge clk); fill_en = 0; lk_valid = 0;
    lookup(4'd3, 20'h00077, 1, 20'h0ABCD, "R9 next sees fill");
    @(negedge clk);
    iid_en = 1; iid_id = 4'd3;
    fill_en = 1; fill_id = 4'd3; fill_vpn = 20'h00078; fill_pfn = 20'h0BCDE;
    lk_valid = 1; lk_id = 4'd3; lk_vpn = 20'h00077;
    @(posedge clk); #1;
    check(rs_hit == 1 && rs_pfn == 20'h0ABCD, "R9 hit before invalidate", {12'd0, rs_pfn}, 32'h0ABCD);
    @(negedge clk); iid_en = 0; fill_en = 0; lk_valid = 0;
    lookup(4'd3, 20'h00077, 0, 0, "R9 invalidate applied");
    lookup(4'd3, 20'h00078, 1, 20'h0BCDE, "R9 fill survives");
  endtask

  task automatic t_backpressure();
    do_reset();
    fill(4'd1, 20'h00010, 20'h0F010);
    fill(4'd1, 20'h00020, 20'h0F020);
    @(negedge clk);
    rs_ready = 0; lk_valid = 1; lk_id = 4'd1; lk_vpn = 20'h00010;
    @(negedge clk);
    lk_vpn = 20'h00020;
    #1;
    check(lk_ready == 0, "R10 ready low", {31'd0, lk_ready}, 0);
    repeat (2) @(negedge clk);
    check(rs_valid && rs_pfn == 20'h0F010, "R10 result held", {12'd0, rs_pfn}, 32'h0F010);
    rs_ready = 1;
    @(posedge clk); #1;
    check(rs_valid && rs_hit && rs_pfn == 20'h0F020, "R10 next accepted", {12'd0, rs_pfn}, 32'h0F020);
    @(negedge clk); lk_valid = 0;
    @(posedge clk); #1;
    check(rs_valid == 0, "R10 drained", {31'd0, rs_valid}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_match();
    t_coexist();
    t_overwrite();
    t_replace();
    t_inv_page();
    t_inv_id();
    t_same_cycle();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule